// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block models a flow-through synchronous static RAM with a short linear burst counter. A new access begins when one of two address strobes is taken. The processor strobe has priority over the controller strobe, but it is honoured only when the first chip select is active. The controller strobe has no such gating. Three chip selects are looked at only on the edge where an address is taken, and they decide whether the part is selected or deselected. Between strobes, a step input moves the two low address bits forward through a 2-bit counter that wraps.

Writes are controlled per 9-bit lane. Each lane holds eight data bits with a parity bit at its top, and a global write input overrides the lane controls. Write data is captured on the edge of the write cycle. Read data for the address current at an edge appears on the output bus during the following cycle. The data bus is split into an input, an output and one drive enable, so that a pad ring or an FPGA I/O buffer can build the bidirectional pins. The drive enable follows the output-enable input combinationally, and it is forced off during write data phases, on the first cycle after leaving deselect, and while deselected. A nap input freezes the block without losing its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After a synchronous active-high reset the block is deselected and dq_oe is 0. A burst step taken before any address load leaves it deselected. Array contents are not cleared by reset.
- R2: On an edge where an address strobe is taken and the part is selected, addr is captured. Flow-through read: the word at the address current after an edge is presented on dq_out during the following cycle.
- R3: The processor strobe ld_cpu_n is ignored when sel_a_n is high. In that case ld_ctl_n low is still taken. With ld_ctl_n also high, the address, the burst position and the selection state are unchanged.
- R4: The part is selected only if sel_a_n is low, sel_b is high and sel_c_n is low on the edge of an address load. Otherwise it becomes deselected. The selects are ignored on edges without a load.
- R5: On an edge without a load while selected, burst_step_n low adds one to the two low address bits. The count wraps from 3 to 0 with no carry into the upper bits.
- R6: An edge without a load while selected, with any lane enabled, writes dq_in into the enabled lanes at the address current before that edge. A burst step in the same cycle takes effect after the write.
- R7: wr_all_n low writes every lane, whatever wr_byte_n and lane_sel_n are.
- R8: With wr_all_n high, lane i (dq bits i*9 to i*9+8, bit i*9+8 being its parity) is written only when wr_byte_n is low and lane_sel_n[i] is low. With wr_byte_n high no lane is written.
- R9: dq_oe is 1 only during a read data phase with out_en_n low, and it follows out_en_n without waiting for a clock. It is 0 in the cycle after a write edge, in the first cycle after a load that leaves deselect, and while deselected.
- R10: On an edge with nap high, strobes, steps and writes are ignored. dq_oe is 0 in the following cycle, and the address and the stored data are preserved.
- R11: An edge that takes an address strobe never writes. The write controls are ignored there and the cycle is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | External word address |
| ld_cpu_n | input | 1 | Processor address strobe, active low, priority |
| ld_ctl_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| burst_step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| nap | input | 1 | Sleep, active high |
| dq_in | input | NB*LW | Write data from the bus |
| dq_out | output | NB*LW | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Two functions can share a single edge. A write can land together with a burst step, and a strobe load can arrive while the write controls are active. The bench provokes the first case with a run of global writes that keep burst_step_n low through the counter wrap. It judges the result by reading back each word and by finding that the wrap landed on the base address. The second case is provoked by a processor load with wr_all_n low and foreign data on dq_in. It passes only if the read that follows shows the old contents.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // bus phase of the cycle that follows an edge
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_FIRST = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;
endpackage

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          ld_cpu_n,
  input  logic          ld_ctl_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          burst_step_n,
  input  logic          nap,
  input  logic          wr_req,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr,
  output logic          wr_fire,
  output phase_e        phase
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q, hi_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          act_q, act_d;
  phase_e        ph_q, ph_d;
  logic          awake, take_cpu, take_ctl, load, chosen, step;

  always_comb begin
    awake    = !nap;
    take_cpu = awake && !ld_cpu_n && !sel_a_n;
    take_ctl = awake && !take_cpu && !ld_ctl_n;
    load     = take_cpu || take_ctl;
    chosen   = !sel_a_n && sel_b && !sel_c_n;
    step     = awake && !load && act_q && !burst_step_n;
    wr_fire  = awake && !load && act_q && wr_req;

    hi_d  = hi_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      act_d = chosen;
      if (chosen) begin
        hi_d  = addr[AW-1:2];
        cnt_d = addr[1:0];
      end
    end else if (step) begin
      cnt_d = cnt_q + 2'd1;
    end

    if (!act_d || !awake)    ph_d = PH_OFF;
    else if (load && !act_q) ph_d = PH_FIRST;
    else if (wr_fire)        ph_d = PH_WRITE;
    else                     ph_d = PH_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      ph_q  <= PH_OFF;
    end else begin
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      ph_q  <= ph_d;
    end
  end

  assign cur_addr = {hi_q, cnt_q};
  assign nxt_addr = {hi_d, cnt_d};
  assign phase    = ph_q;

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!nap && !ld_cpu_n && !sel_a_n && sel_b && !sel_c_n) |=> (cur_addr == $past(addr))); // R2
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    (!ld_cpu_n && sel_a_n && ld_ctl_n && burst_step_n) |=> ($stable(cur_addr) && $stable(act_q))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (act_q && !nap && ld_cpu_n && ld_ctl_n && !burst_step_n)
      |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R5
  AST_NAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    nap |=> ($stable(cur_addr) && phase == PH_OFF)); // R10
endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
  parameter int NB = 2
) (
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] lane_sel_n,
  output logic [NB-1:0] mask
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign mask[i] = !wr_all_n || (!wr_byte_n && !lane_sel_n[i]);
  end
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW = 6,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [LW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             ld_cpu_n,
  input  logic             ld_ctl_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             burst_step_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [NB-1:0]    lane_sel_n,
  input  logic             out_en_n,
  input  logic             nap,
  input  logic [NB*LW-1:0] dq_in,
  output logic [NB*LW-1:0] dq_out,
  output logic             dq_oe
);
  logic [AW-1:0] cur_addr, nxt_addr;
  logic [NB-1:0] mask, lane_we;
  logic          wr_fire;
  phase_e        phase;

  sbs_lane_dec #(.NB(NB)) u_dec (
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_sel_n(lane_sel_n),
    .mask      (mask)
  );

  sbs_burst_ctl #(.AW(AW)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .ld_cpu_n    (ld_cpu_n),
    .ld_ctl_n    (ld_ctl_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .burst_step_n(burst_step_n),
    .nap         (nap),
    .wr_req      (|mask),
    .cur_addr    (cur_addr),
    .nxt_addr    (nxt_addr),
    .wr_fire     (wr_fire),
    .phase       (phase)
  );

  assign lane_we = mask & {NB{wr_fire}};

  for (genvar i = 0; i < NB; i++) begin : g_ram
    sbs_lane_ram #(.AW(AW), .LW(LW)) u_ram (
      .clk  (clk),
      .we   (lane_we[i]),
      .waddr(cur_addr),
      .wdata(dq_in[i*LW +: LW]),
      .raddr(nxt_addr),
      .rdata(dq_out[i*LW +: LW])
    );
  end

  // output enable acts without a clock; phase masks write, first and off cycles
  assign dq_oe = (phase == PH_READ) && !out_en_n;

  AST_WR_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(wr_fire) |-> !dq_oe); // R9
  AST_GW_ALL: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !wr_all_n) |-> ($countones(lane_we) == NB)); // R7
  AST_BWE_NONE: assert property (@(posedge clk) disable iff (rst)
    (wr_all_n && wr_byte_n) |-> (lane_we == '0)); // R8
  AST_LOAD_NO_WR: assert property (@(posedge clk) disable iff (rst)
    (!nap && (!ld_ctl_n || (!ld_cpu_n && !sel_a_n))) |-> (lane_we == '0)); // R11
endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  typedef struct packed {
    logic [11:0] ctl;  // cpu ctl selA selB selC step all byte lane[1:0] oe nap
    logic [5:0]  a;
    logic [17:0] wd;
    logic        ez;   // expect bus not driven
    logic [17:0] ex;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{12'b1_0_0_1_0_1_1_1_11_0_0, 6'h08, 18'h00000, 1'b1, 18'h0},     // 0 R9 first after deselect
    '{12'b1_1_0_1_0_1_0_1_11_1_0, 6'h00, 18'h1A5A5, 1'b1, 18'h0},     // 1 R7 write addr8
    '{12'b1_1_0_1_0_0_0_1_11_1_0, 6'h00, 18'h0F0F1, 1'b1, 18'h0},     // 2 R6 write+step
    '{12'b1_1_0_1_0_0_0_1_11_1_0, 6'h00, 18'h23456, 1'b1, 18'h0},     // 3 R6 addr9
    '{12'b1_1_0_1_0_0_0_1_11_1_0, 6'h00, 18'h3C3C3, 1'b1, 18'h0},     // 4 R6 addr10
    '{12'b1_1_0_1_0_0_0_1_11_1_0, 6'h00, 18'h11111, 1'b1, 18'h0},     // 5 R5 addr11 wrap
    '{12'b1_1_0_1_0_1_1_0_10_1_0, 6'h00, 18'h3FFFF, 1'b1, 18'h0},     // 6 R8 lane0 only
    '{12'b1_1_0_1_0_1_1_1_00_0_0, 6'h00, 18'h00000, 1'b0, 18'h0F1FF}, // 7 R8 byte enable high
    '{12'b0_1_0_1_0_1_0_1_11_0_0, 6'h09, 18'h00000, 1'b0, 18'h23456}, // 8 R2 R11 load ignores write
    '{12'b1_1_0_1_0_0_1_1_11_0_0, 6'h00, 18'h00000, 1'b0, 18'h3C3C3}, // 9 R5 step
    '{12'b0_1_1_1_0_1_1_1_11_0_0, 6'h20, 18'h00000, 1'b0, 18'h3C3C3}, // 10 R3 gated cpu strobe
    '{12'b0_0_1_1_0_1_1_1_11_0_0, 6'h20, 18'h00000, 1'b1, 18'h0},     // 11 R3 R4 ctl deselects
    '{12'b1_1_0_1_0_0_1_1_11_0_0, 6'h00, 18'h00000, 1'b1, 18'h0},     // 12 R9 deselected
    '{12'b1_0_0_1_0_1_1_1_11_0_0, 6'h0B, 18'h00000, 1'b1, 18'h0},     // 13 R9 first cycle
    '{12'b1_1_0_1_0_1_1_1_11_0_0, 6'h00, 18'h00000, 1'b0, 18'h11111}, // 14 R2 read addr11
    '{12'b1_1_0_1_0_0_1_1_11_0_0, 6'h00, 18'h00000, 1'b0, 18'h0F1FF}, // 15 R5 wrap to addr8
    '{12'b0_1_0_1_0_1_0_1_11_0_1, 6'h10, 18'h2AAAA, 1'b1, 18'h0},     // 16 R10 nap
    '{12'b1_1_0_1_0_1_1_1_11_0_0, 6'h00, 18'h00000, 1'b0, 18'h0F1FF}, // 17 R10 preserved
    '{12'b1_0_0_0_0_1_1_1_11_0_0, 6'h0A, 18'h00000, 1'b1, 18'h0},     // 18 R4 selB low
    '{12'b1_0_0_1_0_1_1_1_11_0_0, 6'h0A, 18'h00000, 1'b1, 18'h0},     // 19 R4 reselect first
    '{12'b1_1_0_1_0_1_1_0_01_1_0, 6'h00, 18'h3FE00, 1'b1, 18'h0},     // 20 R8 lane1 only
    '{12'b1_1_0_1_0_1_1_1_11_0_0, 6'h00, 18'h00000, 1'b0, 18'h3FFC3}, // 21 R8 readback
    '{12'b1_1_0_1_0_1_0_1_11_1_0, 6'h00, 18'h15555, 1'b1, 18'h0},     // 22 R7 all lanes
    '{12'b1_1_0_1_0_1_1_1_11_0_0, 6'h00, 18'h00000, 1'b0, 18'h15555}, // 23 R7 readback
    '{12'b1_1_0_1_0_1_1_1_11_1_0, 6'h00, 18'h00000, 1'b1, 18'h0}      // 24 R9 oe high
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        ld_cpu_n = 1'b1, ld_ctl_n = 1'b1, sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic        burst_step_n = 1'b1, wr_all_n = 1'b1, wr_byte_n = 1'b1, out_en_n = 1'b0, nap = 1'b0;
  logic [1:0]  lane_sel_n = 2'b11;
  logic [17:0] dq_in = '0;
  logic [17:0] dq_out;
  logic        dq_oe;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  sync_burst_sram #(.AW(6), .NB(2), .LW(9)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_step_n(burst_step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .nap(nap), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic apply(input vec_t v);
    {ld_cpu_n, ld_ctl_n, sel_a_n, sel_b, sel_c_n, burst_step_n,
     wr_all_n, wr_byte_n, lane_sel_n, out_en_n, nap} = v.ctl;
    addr  = v.a;
    dq_in = v.wd;
  endtask

  task automatic check(input string rq, input logic ez, input logic [17:0] ex);
    total++;
    if (ez) begin
      if (dq_oe !== 1'b0) begin
        bad++;
        $display("FAIL %s: dq_oe=%b expected 0", rq, dq_oe);
      end
    end else if (dq_oe !== 1'b1 || dq_out !== ex) begin
      bad++;
      $display("FAIL %s: dq_oe=%b dq_out=%h expected 1/%h", rq, dq_oe, dq_out, ex);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b1, 18'h0);  // reset state: bus off
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d", i), TBL[i].ez, TBL[i].ex);
    end
    // R9: output enable takes effect without a clock edge
    #2 out_en_n = 1'b0;
    #2 check("R9", 1'b0, 18'h15555);
    // R1: reset mid-run deselects
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 1'b1, 18'h0);
    apply(TBL[9]);  // step without load
    @(posedge clk);
    @(negedge clk);
    check("R1", 1'b1, 18'h0);
    apply(TBL[0]);  // reload addr8
    @(posedge clk);
    @(negedge clk);
    apply(TBL[14]);
    @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, 18'h0F1FF);  // contents survive reset
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule